// File: doc/BRIEF.md
# Upset-Tolerant Three-State Controller

This block is a small control sequencer whose state register survives single radiation-induced bit upsets. The current state is held as a 5-bit code. The three legal states are placed at a Hamming distance of at least three from one another. On every clock the register contents are decoded to the nearest legal state. Any code within one bit of a legal state is accepted as that state. The register is then rewritten with the clean code of the state the machine moves to, so a lone upset is removed within one clock.

A code that is two or more bits away from every legal state cannot be attributed to a state. It is treated as an error. The machine then returns to its home state and raises a sticky error flag, which only a synchronous reset clears.

Three request inputs advance the machine around the ring A to B to C and back to A. A fault-injection input XORs a chosen mask into the register, so that a testbench can place any code in it. All pins are plain control and status signals. There is no data stream, so the block has no valid/ready handshake.

Top module: `seu_guard_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the register is set to the code of state A and `err_o` is cleared. After that edge, `state_o` is 0, `fixed_o` is 0 and `err_o` is 0. Reset overrides the requests and the fault injection. `state_o` encodes A as 0, B as 1 and C as 2.
- R2: When the register holds a code at distance 0 or 1 from a legal code, `state_o` reports that state. The legal codes are A = 00000, B = 00111 and C = 11001.
- R3: Suppose the register holds a code one bit away from a legal code, and no valid request or injection is present. On the next edge the register is rewritten with that state's clean code. `state_o` is unchanged and `fixed_o` returns to 0.
- R4: Each request moves the machine on the next edge: `go_x` from A to B, `go_y` from B to C, and `go_z` from C to A.
- R5: A request that is not valid in the current state has no effect, and the state is unchanged after the edge.
- R6: Suppose a valid request arrives while the register holds a single-flip code. The machine takes the transition of the associated state and writes the clean destination code, so `fixed_o` is 0 after the edge.
- R7: `fixed_o` is high exactly while the register holds a code at distance 1 from a legal code.
- R8: Suppose the register holds a code at distance 2 or more from every legal code. While it does, `state_o` shows 0 and `fixed_o` is 0. On the next edge the register is set to A and `err_o` rises.
- R9: Once set, `err_o` stays high until reset. While it is high, `state_o` shows A and all requests are ignored.
- R10: When `flip_mask` is nonzero at an edge (and `rst` is low), the register takes its current value XOR `flip_mask`. This takes precedence over requests and correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go_x | input | 1 | Request A to B |
| go_y | input | 1 | Request B to C |
| go_z | input | 1 | Request C to A |
| flip_mask | input | 5 | Fault injection mask XORed into the state register |
| state_o | output | 2 | Decoded state (0 = A, 1 = B, 2 = C) |
| fixed_o | output | 1 | High while the register holds a correctable, non-clean code |
| err_o | output | 1 | Sticky uncorrectable-code flag |

## Verification
The outputs are decoded directly from the register, so a wrong internal code appears in the first cycle after the edge that produced it. A wrong code shows up as a wrong `state_o`, as `fixed_o` high after a repair should have happened, or as `err_o` set or missing one cycle after an uncorrectable code. The sweep injects every nonzero mask into each legal state and compares the result with distances computed in the bench. A faulty decode, repair or error path therefore shows within one or two cycles of the injection.

// File: rtl/seu_fsm_pkg.sv
package seu_fsm_pkg;
  localparam int CODE_W  = 5;
  localparam int NUM_ST  = 3;
  localparam int ST_W    = $clog2(NUM_ST);
  localparam int RADIUS  = 1;
  localparam int DIST_W  = $clog2(CODE_W + 1);

  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic [ST_W-1:0] {ST_A = 2'd0, ST_B = 2'd1, ST_C = 2'd2} st_e;

  function automatic code_t code_of(st_e s);
    case (s)
      ST_A:    code_of = 5'b00000;
      ST_B:    code_of = 5'b00111;
      ST_C:    code_of = 5'b11001;
      default: code_of = 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/seu_code_decoder.sv
module seu_code_decoder
  import seu_fsm_pkg::*;
(
  input  code_t code_i,
  output st_e   st_o,
  output logic  ok_o,
  output logic  dirty_o
);
  logic [NUM_ST-1:0] near_w;
  logic [NUM_ST-1:0] exact_w;

  for (genvar i = 0; i < NUM_ST; i++) begin : g_dist
    logic [DIST_W-1:0] dist_w;
    always_comb begin
      dist_w     = DIST_W'($countones(code_i ^ code_of(st_e'(i))));
      near_w[i]  = (dist_w <= DIST_W'(RADIUS));
      exact_w[i] = (dist_w == '0);
    end
  end

  // Legal codes are at distance >= 3, so at most one near_w bit is set.
  always_comb begin
    st_o = ST_A;
    for (int i = NUM_ST - 1; i >= 0; i--) begin
      if (near_w[i]) st_o = st_e'(i);
    end
    ok_o    = |near_w;
    dirty_o = (|near_w) && !(|exact_w);
  end
endmodule

// File: rtl/seu_next_state.sv
module seu_next_state
  import seu_fsm_pkg::*;
(
  input  st_e   st_i,
  input  logic  ok_i,
  input  logic  err_i,
  input  logic  go_x,
  input  logic  go_y,
  input  logic  go_z,
  output code_t code_o,
  output logic  err_o
);
  st_e dest;

  always_comb begin
    dest = st_i;
    if (!ok_i || err_i) begin
      dest = ST_A;
    end else begin
      case (st_i)
        ST_A:    if (go_x) dest = ST_B;
        ST_B:    if (go_y) dest = ST_C;
        ST_C:    if (go_z) dest = ST_A;
        default: dest = ST_A;
      endcase
    end
    code_o = code_of(dest);
    err_o  = err_i || !ok_i;
  end
endmodule

// File: rtl/seu_state_reg.sv
module seu_state_reg
  import seu_fsm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  code_t flip_mask,
  input  code_t nxt_code,
  input  logic  nxt_err,
  output code_t st_q,
  output logic  err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= code_of(ST_A);
      err_q <= 1'b0;
    end else begin
      st_q  <= (flip_mask != '0) ? (st_q ^ flip_mask) : nxt_code;
      err_q <= nxt_err;
    end
  end
endmodule

// File: rtl/seu_guard_fsm.sv
module seu_guard_fsm
  import seu_fsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_x,
  input  logic              go_y,
  input  logic              go_z,
  input  logic [CODE_W-1:0] flip_mask,
  output logic [ST_W-1:0]   state_o,
  output logic              fixed_o,
  output logic              err_o
);
  code_t st_q;
  logic  err_q;
  st_e   dec_st;
  logic  dec_ok;
  logic  dec_dirty;
  logic  dec_err;
  code_t nxt_code;
  logic  nxt_err;

  seu_code_decoder u_dec (
    .code_i (st_q),
    .st_o   (dec_st),
    .ok_o   (dec_ok),
    .dirty_o(dec_dirty)
  );

  seu_next_state u_nxt (
    .st_i  (dec_st),
    .ok_i  (dec_ok),
    .err_i (err_q),
    .go_x  (go_x),
    .go_y  (go_y),
    .go_z  (go_z),
    .code_o(nxt_code),
    .err_o (nxt_err)
  );

  seu_state_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .flip_mask(flip_mask),
    .nxt_code (nxt_code),
    .nxt_err  (nxt_err),
    .st_q     (st_q),
    .err_q    (err_q)
  );

  assign dec_err = !dec_ok;
  assign state_o = err_q ? ST_A : dec_st;
  assign fixed_o = dec_dirty;
  assign err_o   = err_q;
endmodule

// File: rtl/seu_guard_fsm_chk.sv
module seu_guard_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       go_x,
  input logic       go_y,
  input logic       go_z,
  input logic [4:0] flip_mask,
  input logic [1:0] state_o,
  input logic       fixed_o,
  input logic       err_o,
  input logic [4:0] st_q,
  input logic       dec_err
);
  p_repair_r3: assert property (@(posedge clk) disable iff (rst)
    (fixed_o && flip_mask == 5'd0 && !go_x && !go_y && !go_z)
    |=> (!fixed_o && state_o == $past(state_o)));

  p_step_x_r4: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !dec_err && state_o == 2'd0 && go_x && flip_mask == 5'd0)
    |=> (state_o == 2'd1 && !fixed_o));

  p_step_z_r4: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !dec_err && state_o == 2'd2 && go_z && flip_mask == 5'd0)
    |=> (state_o == 2'd0 && !fixed_o));

  p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !dec_err && state_o == 2'd1 && !go_y && flip_mask == 5'd0)
    |=> (state_o == 2'd1));

  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    dec_err |=> err_o);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  p_err_home_r9: assert property (@(posedge clk) disable iff (rst)
    (err_o && flip_mask == 5'd0) |=> (st_q == 5'b00000));

  p_inject_r10: assert property (@(posedge clk) disable iff (rst)
    (flip_mask != 5'd0) |=> (st_q == ($past(st_q) ^ $past(flip_mask))));
endmodule

bind seu_guard_fsm seu_guard_fsm_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .go_x     (go_x),
  .go_y     (go_y),
  .go_z     (go_z),
  .flip_mask(flip_mask),
  .state_o  (state_o),
  .fixed_o  (fixed_o),
  .err_o    (err_o),
  .st_q     (st_q),
  .dec_err  (dec_err)
);

// File: tb/seu_guard_fsm_bench.sv
`timescale 1ns/1ps
module seu_guard_fsm_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go_x = 1'b0, go_y = 1'b0, go_z = 1'b0;
  logic [4:0] flip_mask = 5'd0;
  logic [1:0] state_o;
  logic       fixed_o, err_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seu_guard_fsm u_seu_guard_fsm (
    .clk(clk), .rst(rst), .go_x(go_x), .go_y(go_y), .go_z(go_z),
    .flip_mask(flip_mask), .state_o(state_o), .fixed_o(fixed_o), .err_o(err_o)
  );

  function automatic logic [4:0] code_of(int s);
    case (s)
      0: return 5'b00000;
      1: return 5'b00111;
      default: return 5'b11001;
    endcase
  endfunction

  function automatic int near(logic [4:0] c);
    for (int s = 0; s < 3; s++)
      if ($countones(c ^ code_of(s)) <= 1) return s;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; go_x = 0; go_y = 0; go_z = 0; flip_mask = 5'd0;
    tick();
    rst = 1'b0;
  endtask

  task automatic go_to(int s);
    do_reset();
    if (s >= 1) begin go_x = 1; tick(); go_x = 0; end
    if (s == 2) begin go_y = 1; tick(); go_y = 0; end
  endtask

  task automatic request(int s, bit valid);
    go_x = valid ? (s == 0) : (s != 0);
    go_y = valid ? (s == 1) : (s != 1);
    go_z = valid ? (s == 2) : (s != 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    tick();
    rst = 1'b0;
    // R1: reset state
    chk("R1 state", state_o, 0);
    chk("R1 fixed", fixed_o, 0);
    chk("R1 err", err_o, 0);

    // R4: ring A->B->C->A
    go_x = 1; tick(); go_x = 0; chk("R4 A to B", state_o, 1);
    go_y = 1; tick(); go_y = 0; chk("R4 B to C", state_o, 2);
    go_z = 1; tick(); go_z = 0; chk("R4 C to A", state_o, 0);

    // R5: invalid requests ignored in each state
    for (int s = 0; s < 3; s++) begin
      go_to(s);
      request(s, 1'b0);
      tick();
      go_x = 0; go_y = 0; go_z = 0;
      chk("R5 state kept", state_o, s);
      chk("R5 fixed low", fixed_o, 0);
    end

    // R2 R3 R7 R8 R9 R10: every nonzero mask on every legal state
    for (int s = 0; s < 3; s++) begin
      for (int m = 1; m < 32; m++) begin
        logic [4:0] c;
        int t;
        go_to(s);
        c = code_of(s) ^ 5'(m);
        t = near(c);
        flip_mask = 5'(m);
        tick();
        flip_mask = 5'd0;
        if (t >= 0) begin
          chk("R2 decode", state_o, t);
          chk("R7 fixed", fixed_o, int'(c != code_of(t)));
          chk("R10 no err", err_o, 0);
          tick();
          chk("R3 state kept", state_o, t);
          chk("R3 fixed cleared", fixed_o, 0);
          chk("R3 err low", err_o, 0);
        end else begin
          chk("R8 shows A", state_o, 0);
          chk("R8 fixed low", fixed_o, 0);
          chk("R8 err not yet", err_o, 0);
          tick();
          chk("R8 err set", err_o, 1);
          chk("R8 home", state_o, 0);
          go_x = 1; go_y = 1; go_z = 1;
          tick();
          go_x = 0; go_y = 0; go_z = 0;
          chk("R9 err sticky", err_o, 1);
          chk("R9 requests ignored", state_o, 0);
          tick();
          chk("R9 still sticky", err_o, 1);
          do_reset();
          chk("R1 err cleared", err_o, 0);
          chk("R1 state after err", state_o, 0);
        end
      end
    end

    // R6: transition taken from each single-flip code
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 5; b++) begin
        go_to(s);
        flip_mask = 5'(1 << b);
        tick();
        flip_mask = 5'd0;
        chk("R7 single flip", fixed_o, 1);
        request(s, 1'b1);
        tick();
        go_x = 0; go_y = 0; go_z = 0;
        chk("R6 dest", state_o, (s + 1) % 3);
        chk("R6 clean", fixed_o, 0);
      end
    end

    // R10: injection wins over a request
    go_to(0);
    go_x = 1; flip_mask = 5'b00001;
    tick();
    go_x = 0; flip_mask = 5'd0;
    chk("R10 request blocked", state_o, 0);
    chk("R10 flip visible", fixed_o, 1);

    // R1: reset wins over injection
    rst = 1; flip_mask = 5'b01100; go_x = 1;
    tick();
    rst = 0; flip_mask = 5'd0; go_x = 0;
    chk("R1 reset over inject state", state_o, 0);
    chk("R1 reset over inject fixed", fixed_o, 0);
    chk("R1 reset over inject err", err_o, 0);

    finish_run();
  end
endmodule